// File: doc/BRIEF.md
# Watchdog Timer with Register Interface

This peripheral guards a system against software that has stopped making progress. A down-counter runs from a period of 2^(BASE_SHIFT+n) clock cycles. Software selects n through a 4-bit field, and BASE_SHIFT defaults to 16. Software must keep writing a fixed key value to a restart register. If it stops, the counter runs out and the block requests a system reset.

An optional two-stage response gives software a warning first. In that mode the first expiry raises an interrupt. Reading the interrupt-clear register acknowledges the warning and starts a fresh period. If the count runs out again while the interrupt is still pending, the reset request is issued.

The block sits on a plain 32-bit register bus with an address, a write strobe, a read strobe, write data and combinational read data. It has six word registers: control, timeout select, live count, restart, status and interrupt clear. Once software turns the block on, it can only be turned off by a hardware reset.

Top module: `wdt_top`

## Requirements
- R1: The register map decodes byte addresses as follows. Control is 0x00, with bit 0 as enable and bit 1 as two-stage mode. Timeout select is 0x04, a 4-bit selector in bits 3:0; upper written bits are dropped. Live count is 0x08. Restart is 0x0C, interrupt status is 0x10 and interrupt clear is 0x14. The restart and interrupt-clear registers read as zero.
- R2: Writing 0 to enable after it has been set leaves enable at 1; only the reset input clears it.
- R3: Writing 0x76 to the restart register reloads the counter with 2^(BASE_SHIFT+n)-1 in the next cycle, whether or not the block is enabled; any other written value leaves the counter unchanged.
- R4: While enabled, the counter steps down by one per cycle and expires in the cycle it holds 0, so a reload is followed by an expiry exactly 2^(BASE_SHIFT+n) cycles later. While disabled, the count holds its value.
- R5: With two-stage mode off, an expiry asserts the reset request in the next cycle and raises no interrupt.
- R6: With two-stage mode on and no interrupt pending, an expiry raises the interrupt and does not request a reset.
- R7: With two-stage mode on, an expiry while the interrupt is still pending asserts the reset request.
- R8: The reset request stays high for exactly RST_CYCLES (default 8) consecutive cycles.
- R9: Status bit 0 reads 1 while the interrupt is pending. A read of the interrupt-clear register drops the interrupt and reloads the counter with the full period.
- R10: A new timeout selector is used only at the next reload (key write, interrupt clear or expiry); the running count is not changed by the write.
- R11: After reset, enable, mode, selector and interrupt are 0, the reset request is low, and the count reads 2^BASE_SHIFT-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the accessed register |
| bus_wr | input | 1 | Write strobe, acted on at the rising edge |
| bus_rd | input | 1 | Read strobe; read side effects occur at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| wdt_irq | output | 1 | Pending warning interrupt, level |
| wdt_rst_req | output | 1 | System reset request pulse |

## Verification
A wrong internal state in this block mostly shows up late and indirectly. A wrong reload value, or a count that slips while the block is disabled, only becomes visible through the live-count register or as an interrupt or reset one period early or late. Reading the count one cycle after each reload, and timing the interrupt and reset edges to the exact cycle, catches these errors within a single period. A lost pending flag shows up at the second expiry, when the block gives a second warning instead of a reset. A miscounted pulse shows up RST_CYCLES cycles after the reset request rises.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int SEL_W = 4;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_CTRL    = 8'h00;
    localparam logic [ADDR_W-1:0] A_TSEL    = 8'h04;
    localparam logic [ADDR_W-1:0] A_COUNT   = 8'h08;
    localparam logic [ADDR_W-1:0] A_RESTART = 8'h0C;
    localparam logic [ADDR_W-1:0] A_STATUS  = 8'h10;
    localparam logic [ADDR_W-1:0] A_ICLR    = 8'h14;

    localparam logic [DATA_W-1:0] RESTART_KEY = 32'h0000_0076;

    typedef struct packed {
        logic             en;
        logic             two_stage;
        logic [SEL_W-1:0] sel;
    } cfg_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              irq_i,
    output logic [DATA_W-1:0] rdata_o,
    output cfg_t              cfg_o,
    output logic              kick_o,
    output logic              iclr_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i && addr_i == A_CTRL) begin
            cfg_d.en        = cfg_q.en | wdata_i[0];
            cfg_d.two_stage = wdata_i[1];
        end
        if (wr_i && addr_i == A_TSEL) begin
            cfg_d.sel = wdata_i[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        kick_o = wr_i && (addr_i == A_RESTART) && (wdata_i == RESTART_KEY);
        iclr_o = rd_i && (addr_i == A_ICLR);
        rdata_o = '0;
        unique case (addr_i)
            A_CTRL:   rdata_o = {{(DATA_W-2){1'b0}}, cfg_q.two_stage, cfg_q.en};
            A_TSEL:   rdata_o = {{(DATA_W-SEL_W){1'b0}}, cfg_q.sel};
            A_COUNT:  rdata_o = DATA_W'(count_i);
            A_STATUS: rdata_o = {{(DATA_W-1){1'b0}}, irq_i};
            default:  rdata_o = '0;
        endcase
    end

    assign cfg_o = cfg_q;

    p_en_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.en |=> cfg_q.en);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int BASE_SHIFT = 16,
    parameter int CNT_W = BASE_SHIFT + (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    localparam int SHW = $clog2(BASE_SHIFT + (1 << SEL_W));

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W-1:0] full_val;
    logic [SHW-1:0]   shamt;

    always_comb begin
        shamt    = SHW'(BASE_SHIFT) + SHW'(sel_i);
        full_val = (CNT_W'(1) << shamt) - CNT_W'(1);
        expire_o = en_i && (st_q.count == '0);
        st_d     = st_q;
        if (reload_i || expire_o) begin
            st_d.count = full_val;
        end else if (en_i) begin
            st_d.count = st_q.count - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.count <= (CNT_W'(1) << BASE_SHIFT) - CNT_W'(1);
        else        st_q       <= st_d;
    end

    assign count_o = st_q.count;

    p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !reload_i) |=> $stable(st_q.count));

    p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !reload_i && st_q.count != '0) |=> (st_q.count == $past(st_q.count) - CNT_W'(1)));

    p_reload_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (st_q.count != '0));
endmodule

// File: rtl/wdt_resp.sv
module wdt_resp #(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic two_stage_i,
    input  logic iclr_i,
    output logic irq_o,
    output logic rst_req_o
);
    localparam int LW = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic          irq;
        logic [LW-1:0] left;
    } resp_st_t;

    resp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.left != '0) st_d.left = st_q.left - LW'(1);
        if (expire_i) begin
            if (!two_stage_i) begin
                st_d.left = LW'(RST_CYCLES);
            end else if (!iclr_i) begin
                if (st_q.irq) st_d.left = LW'(RST_CYCLES);
                else          st_d.irq  = 1'b1;
            end
        end
        if (iclr_i) st_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o     = st_q.irq;
    assign rst_req_o = (st_q.left != '0);

    logic [LW:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_q <= '0;
        else if (rst_req_o) run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    p_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && !two_stage_i && !st_q.irq) |=> (rst_req_o && !irq_o));

    p_first_warn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && two_stage_i && !st_q.irq && !iclr_i && !rst_req_o) |=> (irq_o && !rst_req_o));

    p_second_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && two_stage_i && st_q.irq && !iclr_i) |=> rst_req_o);

    p_pulse_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req_o) |-> (run_q == (LW+1)'(RST_CYCLES)));

    p_pulse_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (run_q < (LW+1)'(RST_CYCLES)));

    p_iclr_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        iclr_i |=> !irq_o);
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int BASE_SHIFT = 16,
    parameter int RST_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wdt_irq,
    output logic        wdt_rst_req
);
    localparam int CNT_W = BASE_SHIFT + (1 << SEL_W) - 1;

    cfg_t             cfg;
    logic             kick;
    logic             iclr;
    logic             expire;
    logic [CNT_W-1:0] count;

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr),
        .wr_i    (bus_wr),
        .rd_i    (bus_rd),
        .wdata_i (bus_wdata),
        .count_i (count),
        .irq_i   (wdt_irq),
        .rdata_o (bus_rdata),
        .cfg_o   (cfg),
        .kick_o  (kick),
        .iclr_o  (iclr)
    );

    wdt_counter #(.BASE_SHIFT(BASE_SHIFT), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (cfg.en),
        .sel_i    (cfg.sel),
        .reload_i (kick | iclr),
        .count_o  (count),
        .expire_o (expire)
    );

    wdt_resp #(.RST_CYCLES(RST_CYCLES)) u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .expire_i    (expire),
        .two_stage_i (cfg.two_stage),
        .iclr_i      (iclr),
        .irq_o       (wdt_irq),
        .rst_req_o   (wdt_rst_req)
    );

    p_no_irq_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> !$rose(wdt_irq));
endmodule

// File: tb/wdt_top_test.sv
module wdt_top_test;
    localparam int BS = 4;
    localparam int P0 = 1 << BS;
    localparam int P1 = 1 << (BS + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_irq;
    logic        wdt_rst_req;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    wdt_top #(.BASE_SHIFT(BS), .RST_CYCLES(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_irq(wdt_irq), .wdt_rst_req(wdt_rst_req)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [7:0]  tag;
    } vec_t;

    localparam vec_t VECS [14] = '{
        '{1'b1, 8'h04, 32'h1,  8'd10},
        '{1'b0, 8'h04, 32'h1,  8'd1},
        '{1'b0, 8'h08, 32'd15, 8'd10},
        '{1'b1, 8'h0C, 32'h55, 8'd3},
        '{1'b0, 8'h08, 32'd15, 8'd3},
        '{1'b1, 8'h0C, 32'h76, 8'd3},
        '{1'b0, 8'h08, 32'd31, 8'd3},
        '{1'b0, 8'h0C, 32'h0,  8'd1},
        '{1'b0, 8'h14, 32'h0,  8'd1},
        '{1'b0, 8'h10, 32'h0,  8'd9},
        '{1'b1, 8'h04, 32'h1F, 8'd1},
        '{1'b0, 8'h04, 32'hF,  8'd1},
        '{1'b1, 8'h04, 32'h0,  8'd1},
        '{1'b0, 8'h04, 32'h0,  8'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        #35 rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 irq", {31'b0, wdt_irq}, 0);
        check("R11 rst_req", {31'b0, wdt_rst_req}, 0);
        rd(8'h00, v); check("R11 ctrl", v, 0);
        rd(8'h08, v); check("R11 count", v, P0 - 1);
        wait_n(5);
        rd(8'h08, v); check("R4 hold while disabled", v, P0 - 1);

        // table walk: register map, key, deferred selector
        for (int i = 0; i < 14; i++) begin
            if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
            else begin
                rd(VECS[i].addr, v);
                check($sformatf("R%0d vec%0d", VECS[i].tag, i), v, VECS[i].data);
            end
        end

        // R2 sticky enable, R5 direct reset
        wr(8'h00, 32'h1);
        wr(8'h00, 32'h0);
        rd(8'h00, v); check("R2 enable sticky", v, 32'h1);
        wr(8'h0C, 32'h76);
        rd(8'h08, v); check("R3 reload sel0", v, P0 - 1);
        wait_n(P0 - 2);
        check("R4 no early rst", {31'b0, wdt_rst_req}, 0);
        wait_n(1);
        check("R5 rst at expiry", {31'b0, wdt_rst_req}, 1);
        check("R5 no irq", {31'b0, wdt_irq}, 0);
        wait_n(7);
        check("R8 rst still high", {31'b0, wdt_rst_req}, 1);
        wait_n(1);
        check("R8 rst low after 8", {31'b0, wdt_rst_req}, 0);

        // R6 two-stage first expiry
        wr(8'h00, 32'h3);
        rd(8'h00, v); check("R1 ctrl mode", v, 32'h3);
        wr(8'h0C, 32'h76);
        wait_n(P0 - 1);
        check("R6 no early irq", {31'b0, wdt_irq}, 0);
        wait_n(1);
        check("R6 irq raised", {31'b0, wdt_irq}, 1);
        check("R6 no rst", {31'b0, wdt_rst_req}, 0);
        rd(8'h10, v); check("R9 status pending", v, 1);
        rd(8'h14, v); check("R1 iclr reads 0", v, 0);
        check("R9 irq cleared", {31'b0, wdt_irq}, 0);
        rd(8'h08, v); check("R9 iclr reloads", v, P0 - 1);

        // R7 second expiry while pending
        wait_n(P0 - 2);
        check("R7 before first", {31'b0, wdt_irq}, 0);
        wait_n(1);
        check("R7 first warn", {31'b0, wdt_irq}, 1);
        wait_n(P0 - 1);
        check("R7 no early rst", {31'b0, wdt_rst_req}, 0);
        wait_n(1);
        check("R7 rst on second", {31'b0, wdt_rst_req}, 1);
        check("R7 irq still pending", {31'b0, wdt_irq}, 1);

        // R3 wrong key ignored while running
        wr(8'h0C, 32'h76);
        wr(8'h0C, 32'h77);
        rd(8'h08, v); check("R3 bad key ignored", v, P0 - 2);

        // R10 selector change deferred
        wr(8'h0C, 32'h76);
        wr(8'h04, 32'h1);
        rd(8'h08, v); check("R10 count unchanged", v, P0 - 2);
        wr(8'h0C, 32'h76);
        rd(8'h08, v); check("R10 new period on reload", v, P1 - 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule